// File: doc/BRIEF.md
# Iterative 320-bit Word-Shuffle Permutation Core

This block applies a fixed, unkeyed 320-bit permutation to a state held as five 64-bit words (word A in the top 64 bits, word E in the bottom 64 bits). The permutation has sixteen steps. In each step, an eight-round 64-bit nonlinear box runs on words A, C and E in parallel. Next, the step mixes words using three step constants. Finally, it reorders the five words with a fixed shuffle. An internal 7-bit LFSR generates every round and step constant, so the caller supplies only the state.

A caller presents a 320-bit state together with a one-cycle start strobe. The core then runs one box round per clock for 128 clocks. At the end it raises a one-cycle completion flag and updates a result register. The result register keeps its value until the next permutation completes. The block is meant to sit under a sponge-mode controller, which handles padding, keys, absorbing and squeezing.

Top module: `perm320_core`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `stateOut` is all zeros.
- R2: A start is accepted only when `startReq` is 1 and `busy` is 0. In that case `stateIn` is captured and `busy` reads 1 on the next cycle.
- R3: `done` is asserted exactly 128 clock edges after the edge that accepted the start, and is high for one cycle only. `busy` is 0 whenever `done` is 1.
- R4: A box round splits a 64-bit word into halves (hi, lo), with hi in bits 63:32. It produces new hi = (rotl5(hi) AND hi) XOR rotl1(hi) XOR lo XOR {31 ones, rc}, and new lo = old hi. Here rotlN is a left rotation by N bits. The box is eight such rounds and is applied to A, C and E in every step.
- R5: After the eight box rounds of a step, the step mixes words in this order: B ^= C ^ k0, then D ^= E ^ k1, then E ^= A ^ k2. Each kj is the 8-bit step constant scj placed in the low byte with bits 63:8 all ones.
- R6: After the mix, the new words (A,B,C,D,E) become the old words (D,C,A,E,B), which is the (3,2,0,4,1) shuffle.
- R7: The constant generator is a 7-bit register s that is set to 7'h7F on an accepted start. Each round it advances to {s[5:0], s[6]^s[5]}. A round uses rc = s[0] for A, s[1] for C and s[2] for E. A step's constants come from the s value of its eighth round: sc0 = {1'b0,s}, sc1 = {1'b1,s}, sc2 = {s,1'b1}.
- R8: A start request while `busy` is 1 is ignored: the running permutation's result is unaffected and no extra completion occurs.
- R9: `stateOut` changes only in the cycle where `done` is 1. It holds its value otherwise, including while `stateIn` changes and while a new permutation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start strobe, sampled when idle |
| stateIn | input | 320 | State to permute, word A in bits 319:256 |
| busy | output | 1 | Permutation in progress |
| done | output | 1 | One-cycle pulse: `stateOut` has just been updated |
| stateOut | output | 320 | Last completed permutation result |

## Verification
The checker treats `startReq` as meaningful only when `busy` is low. It therefore allows start pulses at any time, including the middle of a run. The bench drives inputs on the falling edge and holds `startReq` for a single cycle per request. The bench also raises `startReq` once during a run with a different `stateIn`, to show that such a request is ignored. `stateIn` is only needed in the accepting cycle, so the bench changes it freely while the core is busy or idle, and the checker's stability rule on `stateOut` must hold through those changes.

// File: rtl/perm320_pkg.sv
package perm320_pkg;
  localparam int WORD_W  = 64;
  localparam int N_WORDS = 5;
  localparam int HALF_W  = WORD_W / 2;
  localparam int CONST_W = 8;

  typedef struct packed {
    logic load;      // accepted start: capture state, reset constants
    logic advance;   // one box round this cycle
    logic stepLast;  // last round of a step: mix and shuffle
    logic finish;    // last round of the last step: publish result
  } ctrlStrobes_t;

  function automatic logic [HALF_W-1:0] rotl(input logic [HALF_W-1:0] x, input int n);
    return (x << n) | (x >> (HALF_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] boxRound(input logic [WORD_W-1:0] w, input logic rc);
    logic [HALF_W-1:0] hi, lo, nh;
    hi = w[WORD_W-1:HALF_W];
    lo = w[HALF_W-1:0];
    nh = ((rotl(hi, 5) & hi) ^ rotl(hi, 1)) ^ lo ^ {{(HALF_W-1){1'b1}}, rc};
    return {nh, hi};
  endfunction
endpackage

// File: rtl/perm320_ctrl.sv
module perm320_ctrl
  import perm320_pkg::*;
#(
  parameter int ROUNDS = 8,
  parameter int STEPS  = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         done
);
  localparam int RW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [RW-1:0] LAST_ROUND = RW'(ROUNDS - 1);
  localparam logic [SW-1:0] LAST_STEP  = SW'(STEPS - 1);

  logic [RW-1:0] roundCnt;
  logic [SW-1:0] stepCnt;

  always_comb begin
    strobes.load     = startReq && !busy;
    strobes.advance  = busy;
    strobes.stepLast = busy && (roundCnt == LAST_ROUND);
    strobes.finish   = busy && (roundCnt == LAST_ROUND) && (stepCnt == LAST_STEP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      roundCnt <= '0;
      stepCnt  <= '0;
    end else begin
      done <= strobes.finish;
      if (strobes.load) begin
        busy     <= 1'b1;
        roundCnt <= '0;
        stepCnt  <= '0;
      end else if (busy) begin
        if (strobes.stepLast) begin
          roundCnt <= '0;
          stepCnt  <= stepCnt + 1'b1;
        end else begin
          roundCnt <= roundCnt + 1'b1;
        end
        if (strobes.finish) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/perm320_constgen.sv
module perm320_constgen
  import perm320_pkg::*;
#(
  parameter int LFSR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  output logic [2:0]        rc,
  output logic [LFSR_W:0]   sc0,
  output logic [LFSR_W:0]   sc1,
  output logic [LFSR_W:0]   sc2
);
  logic [LFSR_W-1:0] seq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                seq <= '1;
    else if (strobes.load)    seq <= '1;
    else if (strobes.advance) seq <= {seq[LFSR_W-2:0], seq[LFSR_W-1] ^ seq[LFSR_W-2]};
  end

  assign rc  = seq[2:0];
  assign sc0 = {1'b0, seq};
  assign sc1 = {1'b1, seq};
  assign sc2 = {seq, 1'b1};
endmodule

// File: rtl/perm320_datapath.sv
module perm320_datapath
  import perm320_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobes_t              strobes,
  input  logic [2:0]                rc,
  input  logic [CONST_W-1:0]        sc0,
  input  logic [CONST_W-1:0]        sc1,
  input  logic [CONST_W-1:0]        sc2,
  input  logic [N_WORDS*WORD_W-1:0] stateIn,
  output logic [N_WORDS*WORD_W-1:0] stateOut
);
  localparam int STATE_W = N_WORDS * WORD_W;

  logic [WORD_W-1:0] word   [N_WORDS];
  logic [WORD_W-1:0] rounded[N_WORDS];
  logic [WORD_W-1:0] mixed  [N_WORDS];
  logic [WORD_W-1:0] nextW  [N_WORDS];
  logic [STATE_W-1:0] resultReg;

  // boxed words sit at even indices A(0), C(2), E(4); odd words pass through
  for (genvar g = 0; g < N_WORDS; g++) begin : gBox
    if (g % 2 == 0) begin : gRound
      assign rounded[g] = boxRound(word[g], rc[g/2]);
    end else begin : gPass
      assign rounded[g] = word[g];
    end
  end

  function automatic logic [WORD_W-1:0] extend(input logic [CONST_W-1:0] k);
    return {{(WORD_W-CONST_W){1'b1}}, k};
  endfunction

  always_comb begin
    mixed[0] = rounded[0];
    mixed[2] = rounded[2];
    mixed[1] = rounded[1] ^ rounded[2] ^ extend(sc0);
    mixed[3] = rounded[3] ^ rounded[4] ^ extend(sc1);
    mixed[4] = rounded[4] ^ rounded[0] ^ extend(sc2);
  end

  always_comb begin
    if (strobes.stepLast) begin
      nextW[0] = mixed[3];
      nextW[1] = mixed[2];
      nextW[2] = mixed[0];
      nextW[3] = mixed[4];
      nextW[4] = mixed[1];
    end else begin
      nextW = rounded;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N_WORDS; i++) word[i] <= '0;
      resultReg <= '0;
    end else begin
      if (strobes.load) begin
        for (int i = 0; i < N_WORDS; i++)
          word[i] <= stateIn[STATE_W-1-i*WORD_W -: WORD_W];
      end else if (strobes.advance) begin
        word <= nextW;
      end
      if (strobes.finish)
        resultReg <= {nextW[0], nextW[1], nextW[2], nextW[3], nextW[4]};
    end
  end

  assign stateOut = resultReg;
endmodule

// File: rtl/perm320_core.sv
module perm320_core
  import perm320_pkg::*;
#(
  parameter int ROUNDS = 8,
  parameter int STEPS  = 16,
  parameter int LFSR_W = 7
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startReq,
  input  logic [N_WORDS*WORD_W-1:0] stateIn,
  output logic                      busy,
  output logic                      done,
  output logic [N_WORDS*WORD_W-1:0] stateOut
);
  ctrlStrobes_t       strobes;
  logic [2:0]         rc;
  logic [LFSR_W:0]    sc0, sc1, sc2;

  perm320_ctrl #(.ROUNDS(ROUNDS), .STEPS(STEPS)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .strobes(strobes), .busy(busy), .done(done)
  );

  perm320_constgen #(.LFSR_W(LFSR_W)) uConst (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rc(rc), .sc0(sc0), .sc1(sc1), .sc2(sc2)
  );

  perm320_datapath uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rc(rc),
    .sc0(sc0), .sc1(sc1), .sc2(sc2),
    .stateIn(stateIn), .stateOut(stateOut)
  );
endmodule

// File: rtl/perm320_checker.sv
module perm320_checker #(
  parameter int ROUNDS = 8,
  parameter int STEPS  = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         startReq,
  input logic         busy,
  input logic         done,
  input logic [319:0] stateOut
);
  localparam int TOTAL = ROUNDS * STEPS;
  int unsigned runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    runCnt <= 0;
    else if (startReq && !busy)   runCnt <= 0;
    else if (busy)                runCnt <= runCnt + 1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rstN |=> (!busy && !done));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> busy);

  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runCnt == TOTAL));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && runCnt < TOTAL - 1) |=> busy);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stateOut) |-> done);
endmodule

bind perm320_core perm320_checker #(.ROUNDS(ROUNDS), .STEPS(STEPS)) uChk (
  .clk(clk), .rstN(rstN), .startReq(startReq),
  .busy(busy), .done(done), .stateOut(stateOut)
);

// File: tb/tb_perm320_core.sv
module tb_perm320_core;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startReq = 1'b0;
  logic [319:0] stateIn = '0;
  logic         busy, done;
  logic [319:0] stateOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [319:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  perm320_core dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stateIn(stateIn),
    .busy(busy), .done(done), .stateOut(stateOut)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  // Reference model built from R4..R7
  function automatic logic [319:0] refPerm(input logic [319:0] st);
    logic [63:0] w[5];
    logic [63:0] t[5];
    logic [6:0]  s;
    logic [31:0] hi, lo;
    logic [7:0]  k0, k1, k2;
    for (int i = 0; i < 5; i++) w[i] = st[319 - 64*i -: 64];
    s = 7'h7F;
    for (int step = 0; step < 16; step++) begin
      for (int r = 0; r < 8; r++) begin
        for (int b = 0; b < 3; b++) begin
          hi = w[2*b][63:32];
          lo = w[2*b][31:0];
          w[2*b] = {(rl(hi,5) & hi) ^ rl(hi,1) ^ lo ^ {31'h7FFFFFFF, s[b]}, hi};
        end
        if (r == 7) begin
          k0 = {1'b0, s}; k1 = {1'b1, s}; k2 = {s, 1'b1};
        end
        s = {s[5:0], s[6] ^ s[5]};
      end
      w[1] = w[1] ^ w[2] ^ {56'hFFFFFFFFFFFFFF, k0};
      w[3] = w[3] ^ w[4] ^ {56'hFFFFFFFFFFFFFF, k1};
      w[4] = w[4] ^ w[0] ^ {56'hFFFFFFFFFFFFFF, k2};
      t[0] = w[3]; t[1] = w[2]; t[2] = w[0]; t[3] = w[4]; t[4] = w[1];
      w = t;
    end
    return {w[0], w[1], w[2], w[3], w[4]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [319:0] act, input logic [319:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Scoreboard monitor: compare each completion against the queue head
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected completion", stateOut, '0);
      end else begin
        logic [319:0] e;
        e = expQ.pop_front();
        check(stateOut === e, "R4/R5/R6/R7 result", stateOut, e);
      end
    end
  end

  // Driver: push expected value, pulse start, measure latency
  task automatic runVector(input logic [319:0] v, input bit interfere);
    int cyc;
    expQ.push_back(refPerm(v));
    @(negedge clk);
    stateIn  = v;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy === 1'b1, "R2 busy after start", {319'b0, busy}, 320'd1);
    cyc = 0;
    while (!done && cyc < 400) begin
      if (interfere && cyc == 40) begin
        stateIn = ~v; startReq = 1'b1;
      end else if (interfere && cyc == 41) begin
        startReq = 1'b0;
      end else if (cyc == 5) begin
        stateIn = {5{64'hDEADBEEF01234567}};
      end
      @(negedge clk);
      cyc++;
    end
    check(cyc == 128, "R3 latency", 320'(cyc), 320'd128);
    check(busy === 1'b0, "R3 idle at done", {319'b0, busy}, 320'd0);
    @(negedge clk);
    check(done === 1'b0, "R3 single pulse", {319'b0, done}, 320'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", '0, '0);
    summary();
  end

  initial begin
    logic [319:0] held;
    logic [319:0] rnd;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy === 1'b0, "R1 busy", {319'b0, busy}, 320'd0);
    check(done === 1'b0, "R1 done", {319'b0, done}, 320'd0);
    check(stateOut === '0, "R1 stateOut", stateOut, '0);
    rstN = 1'b1;
    @(negedge clk);

    runVector('0, 1'b0);
    runVector('1, 1'b0);
    runVector({64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h0F0F0F0F0F0F0F0F,
               64'h8000000000000001, 64'h5555AAAA5555AAAA}, 1'b0);
    rnd = 320'h9E3779B97F4A7C15;
    for (int i = 0; i < 2; i++) begin
      rnd = {rnd[318:0], rnd[319] ^ rnd[318] ^ rnd[316] ^ rnd[313]} ^ (rnd << 37) ^ 320'h1D;
      runVector(rnd, 1'b0);
    end
    // R8: start during a run with different state is ignored
    runVector({5{64'hA5A5A5A5C3C3C3C3}}, 1'b1);

    // R9: result holds while idle and stateIn changes
    held = stateOut;
    for (int i = 0; i < 20; i++) begin
      stateIn = ~stateIn ^ 320'(i);
      @(negedge clk);
    end
    check(stateOut === held, "R9 hold while idle", stateOut, held);

    // R9: result holds during a new run until it completes
    expQ.push_back(refPerm(320'h1));
    @(negedge clk);
    stateIn = 320'h1; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (60) @(negedge clk);
    check(stateOut === held, "R9 hold while busy", stateOut, held);
    while (!done) @(negedge clk);
    @(negedge clk);
    repeat (5) @(negedge clk);

    check(expQ.size() == 0, "R8 all results seen", 320'(expQ.size()), 320'd0);
    summary();
  end
endmodule